// File: doc/BRIEF.md
# Per-Class Transmit Queue Merger

This block holds the pending transmit jobs of one egress port, sorted by priority class. A unicast job is stored as a node in a shared pool and chained onto the tail of its class's linked list. A multicast job goes into one of a small set of physical FIFOs. Each multicast FIFO is tied to one even-numbered unicast class. The list and the FIFO of that class then behave as a single logical queue, served oldest-head-first.

A static mode input selects one of two class layouts. The narrow layout has four unicast classes (0..3) and two multicast FIFOs, paired with classes 0 and 2. The wide layout has eight unicast classes (0..7) and four multicast FIFOs, paired with classes 0, 2, 4 and 6. A free-running counter stamps every job as it arrives. When the port raises its ready input, the block picks the highest-numbered class that holds work. Within that class it takes the older of the two heads, and it presents the chosen handle, its class and its source on the dequeue outputs one cycle later.

The mode may change only while every queue is empty. Frame data movement is handled elsewhere.

Top module: `txq_merge`

## Requirements
- R1: During and after reset all queues are empty: `deq_vld_o` and `mc_ovf_o` are 0, and a ready request with nothing enqueued yields no dequeue.
- R2: A dequeue happens only in a cycle where `port_rdy_i` is 1 and some in-mode queue holds an entry. The result appears on the outputs at the next clock edge, with `deq_vld_o` high for one cycle. No dequeue happens without `port_rdy_i`.
- R3: Unicast jobs of one class leave in the order they were enqueued.
- R4: Multicast jobs of one FIFO leave in the order they were enqueued.
- R5: Multicast FIFO m is served as part of unicast class 2·m. A multicast dequeue reports `deq_cls_o` = 2·m and `deq_mc_o` = 1. Odd classes carry unicast only.
- R6: When both heads of a class are present, the one with the earlier arrival stamp leaves first. Stamps are compared by wrap-safe subtraction. On equal stamps, meaning both were enqueued in the same cycle, the unicast head leaves first. `deq_mc_o` = 0 marks a unicast result.
- R7: Classes are served by strict priority: the highest-numbered non-empty class wins.
- R8: With `gig_mode_i` = 0, a unicast enqueue to class 4..7 and a multicast enqueue to FIFO 2..3 are discarded. They raise no overflow and are never dequeued.
- R9: A multicast enqueue to a FIFO that is full before the edge is discarded, even if that FIFO is popped in the same cycle. `mc_ovf_o` is 1 for exactly the following cycle.
- R10: A unicast enqueue while all NODES pool nodes are in use before the edge is discarded without a flag.
- R11: A job enqueued in the same cycle as a ready request is not eligible for that request. It becomes eligible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gig_mode_i | input | 1 | 1 = eight-class layout, 0 = four-class layout |
| uc_enq_i | input | 1 | Unicast enqueue strobe |
| uc_cls_i | input | 3 | Unicast target class |
| uc_handle_i | input | HANDLE_W | Unicast buffer handle |
| mc_enq_i | input | 1 | Multicast enqueue strobe |
| mc_q_i | input | 2 | Multicast FIFO index |
| mc_handle_i | input | HANDLE_W | Multicast buffer handle |
| port_rdy_i | input | 1 | Egress port ready for its next frame |
| deq_vld_o | output | 1 | Dequeue result valid |
| deq_handle_o | output | HANDLE_W | Dequeued handle |
| deq_cls_o | output | 3 | Class of the dequeued job |
| deq_mc_o | output | 1 | 1 = came from a multicast FIFO |
| mc_ovf_o | output | 1 | Multicast enqueue was dropped last cycle |

## Verification
Enqueue and dequeue can land in the same cycle, often on the same class. The hard cases are a push into a one-entry list while its head is popped, and a push into a full FIFO while that FIFO drains. The bench provokes these with directed sequences and then with long random runs in both modes, where strobes and ready are drawn every cycle. A behavioural model built on plain queues applies the pop to the pre-edge state and the pushes afterwards. Every cycle, the model's prediction of valid, handle, class, source and overflow is compared with the outputs.

// File: rtl/txq_pkg.sv
// Shared constants for the transmit queue merger.
// Assumes the wide layout is the largest one; narrow-layout limits are derived from it.
package txq_pkg;
    localparam int CLS_MAX  = 8;
    localparam int CLS_FAST = 4;
    localparam int CLS_W    = $clog2(CLS_MAX);
    localparam int MCQ_MAX  = CLS_MAX / 2;
    localparam int MCQ_FAST = CLS_FAST / 2;
    localparam int MCQ_W    = $clog2(MCQ_MAX);
endpackage

// File: rtl/txq_uc_list.sv
// Unicast store: a shared node pool plus one singly linked list per class.
// Assumes pop_i is only asserted for a non-empty class. A push with no free node is dropped.
module txq_uc_list #(
    parameter int NODES = 16,
    parameter int HW    = 8,
    parameter int TS_W  = 16,
    parameter int NCLS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  logic [$clog2(NCLS)-1:0] push_cls_i,
    input  logic [HW-1:0]           push_handle_i,
    input  logic [TS_W-1:0]         push_ts_i,
    input  logic                    pop_i,
    input  logic [$clog2(NCLS)-1:0] pop_cls_i,
    output logic [NCLS-1:0]         nonempty_o,
    output logic [HW-1:0]           head_handle_o [NCLS],
    output logic [TS_W-1:0]         head_ts_o [NCLS]
);
    localparam int NW = $clog2(NODES);
    localparam int CW = $clog2(NCLS);

    logic [NODES-1:0] free_q;
    logic [NW-1:0]    nxt_q  [NODES];
    logic [HW-1:0]    hdl_q  [NODES];
    logic [TS_W-1:0]  ts_q   [NODES];
    logic [NW-1:0]    head_q [NCLS];
    logic [NW-1:0]    tail_q [NCLS];
    logic [NW:0]      cnt_q  [NCLS];
    logic [NW-1:0]    alloc;
    logic             any_free;
    logic             acc;

    // Lowest-numbered free node is the allocation candidate.
    always_comb begin
        alloc    = '0;
        any_free = 1'b0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (free_q[i]) begin
                alloc    = NW'(i);
                any_free = 1'b1;
            end
        end
    end

    assign acc = push_i && any_free;

    // Node payload and link storage; written only when a node is allocated or linked.
    always_ff @(posedge clk) begin
        if (acc) begin
            hdl_q[alloc] <= push_handle_i;
            ts_q[alloc]  <= push_ts_i;
            if (cnt_q[push_cls_i] != '0) nxt_q[tail_q[push_cls_i]] <= alloc;
        end
    end

    // Free map, list heads, tails and counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
            for (int c = 0; c < NCLS; c++) begin
                head_q[c] <= '0;
                tail_q[c] <= '0;
                cnt_q[c]  <= '0;
            end
        end else begin
            if (acc) begin
                free_q[alloc]      <= 1'b0;
                tail_q[push_cls_i] <= alloc;
                if (cnt_q[push_cls_i] == '0) head_q[push_cls_i] <= alloc;
            end
            if (pop_i) begin
                free_q[head_q[pop_cls_i]] <= 1'b1;
                if (acc && push_cls_i == pop_cls_i && cnt_q[pop_cls_i] == (NW+1)'(1))
                    head_q[pop_cls_i] <= alloc;
                else
                    head_q[pop_cls_i] <= nxt_q[head_q[pop_cls_i]];
            end
            for (int c = 0; c < NCLS; c++) begin
                case ({acc && push_cls_i == CW'(c), pop_i && pop_cls_i == CW'(c)})
                    2'b10:   cnt_q[c] <= cnt_q[c] + 1'b1;
                    2'b01:   cnt_q[c] <= cnt_q[c] - 1'b1;
                    default: cnt_q[c] <= cnt_q[c];
                endcase
            end
        end
    end

    // Expose each class head.
    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            nonempty_o[c]    = cnt_q[c] != '0;
            head_handle_o[c] = hdl_q[head_q[c]];
            head_ts_o[c]     = ts_q[head_q[c]];
        end
    end
endmodule

// File: rtl/txq_mc_fifo.sv
// One multicast FIFO holding handle and arrival stamp.
// Assumes DEPTH is a power of two, at least 2. A push while full (pre-edge) is dropped.
module txq_mc_fifo #(
    parameter int DEPTH = 4,
    parameter int HW    = 8,
    parameter int TS_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [HW-1:0]   push_handle_i,
    input  logic [TS_W-1:0] push_ts_i,
    input  logic            pop_i,
    output logic            nonempty_o,
    output logic            full_o,
    output logic [HW-1:0]   head_handle_o,
    output logic [TS_W-1:0] head_ts_o
);
    localparam int AW = $clog2(DEPTH);

    logic [HW-1:0]   hdl_mem [DEPTH];
    logic [TS_W-1:0] ts_mem  [DEPTH];
    logic [AW-1:0]   rd_q, wr_q;
    logic [AW:0]     cnt_q;
    logic            wr_en;

    assign full_o     = cnt_q == (AW+1)'(DEPTH);
    assign nonempty_o = cnt_q != '0;
    assign wr_en      = push_i && !full_o;

    // Entry storage.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            hdl_mem[wr_q] <= push_handle_i;
            ts_mem[wr_q]  <= push_ts_i;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wr_q <= wr_q + 1'b1;
            if (pop_i) rd_q <= rd_q + 1'b1;
            case ({wr_en, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_handle_o = hdl_mem[rd_q];
    assign head_ts_o     = ts_mem[rd_q];
endmodule

// File: rtl/txq_hol_select.sv
// Head-of-line selector: strict priority across classes, age order within a class.
// Even class 2m merges multicast FIFO m; equal stamps favour unicast. Purely combinational.
module txq_hol_select
    import txq_pkg::*;
#(
    parameter int HW   = 8,
    parameter int TS_W = 16
) (
    input  logic                gig_i,
    input  logic [CLS_MAX-1:0]  uc_ne_i,
    input  logic [HW-1:0]       uc_hdl_i [CLS_MAX],
    input  logic [TS_W-1:0]     uc_ts_i  [CLS_MAX],
    input  logic [MCQ_MAX-1:0]  mc_ne_i,
    input  logic [HW-1:0]       mc_hdl_i [MCQ_MAX],
    input  logic [TS_W-1:0]     mc_ts_i  [MCQ_MAX],
    output logic                any_o,
    output logic [CLS_W-1:0]    cls_o,
    output logic                pick_mc_o,
    output logic [HW-1:0]       handle_o
);
    logic [CLS_MAX-1:0] live;
    logic [CLS_MAX-1:0] cand_mc;
    logic [HW-1:0]      cand_hdl [CLS_MAX];

    for (genvar c = 0; c < CLS_MAX; c++) begin : g_cls
        if (c % 2 == 0) begin : g_pair
            localparam int M = c / 2;
            logic            m_here;
            logic [TS_W-1:0] diff;
            // Multicast FIFO counts only when its index exists in the current layout.
            assign m_here      = mc_ne_i[M] && (gig_i || (M < MCQ_FAST));
            assign diff        = mc_ts_i[M] - uc_ts_i[c];
            assign cand_mc[c]  = m_here && (!uc_ne_i[c] || diff[TS_W-1]);
            assign cand_hdl[c] = cand_mc[c] ? mc_hdl_i[M] : uc_hdl_i[c];
            assign live[c]     = (gig_i || (c < CLS_FAST)) && (uc_ne_i[c] || m_here);
        end else begin : g_solo
            assign cand_mc[c]  = 1'b0;
            assign cand_hdl[c] = uc_hdl_i[c];
            assign live[c]     = (gig_i || (c < CLS_FAST)) && uc_ne_i[c];
        end
    end

    // Highest live class overrides lower ones.
    always_comb begin
        any_o     = 1'b0;
        cls_o     = '0;
        pick_mc_o = 1'b0;
        handle_o  = '0;
        for (int c = 0; c < CLS_MAX; c++) begin
            if (live[c]) begin
                any_o     = 1'b1;
                cls_o     = CLS_W'(c);
                pick_mc_o = cand_mc[c];
                handle_o  = cand_hdl[c];
            end
        end
    end
endmodule

// File: rtl/txq_merge.sv
// Top: per-class unicast lists and multicast FIFOs of one egress port, merged by age.
// Assumes gig_mode_i changes only while all queues are empty.
module txq_merge
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int NODES    = 16,
    parameter int MC_DEPTH = 4,
    parameter int TS_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gig_mode_i,
    input  logic                uc_enq_i,
    input  logic [2:0]          uc_cls_i,
    input  logic [HANDLE_W-1:0] uc_handle_i,
    input  logic                mc_enq_i,
    input  logic [1:0]          mc_q_i,
    input  logic [HANDLE_W-1:0] mc_handle_i,
    input  logic                port_rdy_i,
    output logic                deq_vld_o,
    output logic [HANDLE_W-1:0] deq_handle_o,
    output logic [2:0]          deq_cls_o,
    output logic                deq_mc_o,
    output logic                mc_ovf_o
);
    logic [TS_W-1:0]     ts_q;
    logic                uc_push, mc_push, pop;
    logic [CLS_MAX-1:0]  uc_ne;
    logic [HANDLE_W-1:0] uc_hdl [CLS_MAX];
    logic [TS_W-1:0]     uc_ts  [CLS_MAX];
    logic [MCQ_MAX-1:0]  mc_ne, mc_full;
    logic [HANDLE_W-1:0] mc_hdl [MCQ_MAX];
    logic [TS_W-1:0]     mc_ts  [MCQ_MAX];
    logic                sel_any, sel_mc;
    logic [CLS_W-1:0]    sel_cls;
    logic [HANDLE_W-1:0] sel_hdl;

    // Arrival stamp source.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    assign uc_push = uc_enq_i && (gig_mode_i || !uc_cls_i[CLS_W-1]);
    assign mc_push = mc_enq_i && (gig_mode_i || !mc_q_i[MCQ_W-1]);
    assign pop     = port_rdy_i && sel_any;

    txq_uc_list #(.NODES(NODES), .HW(HANDLE_W), .TS_W(TS_W), .NCLS(CLS_MAX)) u_uc (
        .clk(clk), .rst_n(rst_n),
        .push_i(uc_push), .push_cls_i(uc_cls_i), .push_handle_i(uc_handle_i), .push_ts_i(ts_q),
        .pop_i(pop && !sel_mc), .pop_cls_i(sel_cls),
        .nonempty_o(uc_ne), .head_handle_o(uc_hdl), .head_ts_o(uc_ts)
    );

    for (genvar m = 0; m < MCQ_MAX; m++) begin : g_mc
        txq_mc_fifo #(.DEPTH(MC_DEPTH), .HW(HANDLE_W), .TS_W(TS_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push_i(mc_push && mc_q_i == MCQ_W'(m)), .push_handle_i(mc_handle_i), .push_ts_i(ts_q),
            .pop_i(pop && sel_mc && sel_cls[CLS_W-1:1] == MCQ_W'(m)),
            .nonempty_o(mc_ne[m]), .full_o(mc_full[m]),
            .head_handle_o(mc_hdl[m]), .head_ts_o(mc_ts[m])
        );
    end

    txq_hol_select #(.HW(HANDLE_W), .TS_W(TS_W)) u_sel (
        .gig_i(gig_mode_i),
        .uc_ne_i(uc_ne), .uc_hdl_i(uc_hdl), .uc_ts_i(uc_ts),
        .mc_ne_i(mc_ne), .mc_hdl_i(mc_hdl), .mc_ts_i(mc_ts),
        .any_o(sel_any), .cls_o(sel_cls), .pick_mc_o(sel_mc), .handle_o(sel_hdl)
    );

    // Registered dequeue result and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deq_vld_o    <= 1'b0;
            deq_handle_o <= '0;
            deq_cls_o    <= '0;
            deq_mc_o     <= 1'b0;
            mc_ovf_o     <= 1'b0;
        end else begin
            deq_vld_o <= pop;
            if (pop) begin
                deq_handle_o <= sel_hdl;
                deq_cls_o    <= sel_cls;
                deq_mc_o     <= sel_mc;
            end
            mc_ovf_o <= mc_push && mc_full[mc_q_i];
        end
    end
endmodule

// File: rtl/txq_merge_chk.sv
// Property checker for txq_merge, attached by bind.
module txq_merge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gig_mode_i,
    input logic       mc_enq_i,
    input logic       port_rdy_i,
    input logic       deq_vld_o,
    input logic [2:0] deq_cls_o,
    input logic       deq_mc_o,
    input logic       mc_ovf_o
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!deq_vld_o && !mc_ovf_o));
    // R2
    deq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_vld_o |-> $past(port_rdy_i));
    // R5
    mc_even_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_vld_o && deq_mc_o) |-> !deq_cls_o[0]);
    // R8
    narrow_class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_vld_o && !$past(gig_mode_i)) |-> !deq_cls_o[2]);
    // R9
    ovf_follows_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_ovf_o |-> $past(mc_enq_i));
endmodule

bind txq_merge txq_merge_chk u_chk (.*);

// File: tb/tb_txq_merge.sv
// Bench: behavioural queue model stepped every clock and compared with the outputs.
// Time unit is 1 ns; the clock period is 4 units.
module tb_txq_merge;
    localparam int HW = 8, NODES = 16, MCD = 4;

    typedef struct { int h; int t; } ent_t;

    logic clk = 1'b0, rst_n = 1'b0, gig = 1'b0;
    logic uc_enq = 1'b0, mc_enq = 1'b0, rdy = 1'b0;
    logic [2:0] uc_cls = '0;
    logic [1:0] mc_q = '0;
    logic [HW-1:0] uc_h = '0, mc_h = '0;
    logic deq_vld, deq_mc, mc_ovf;
    logic [HW-1:0] deq_h;
    logic [2:0] deq_cls;

    int vectors = 0, misc = 0, cyc = 0;
    bit done = 0;
    ent_t uq [8][$];
    ent_t mq [4][$];

    always #2 clk = ~clk;

    txq_merge #(.HANDLE_W(HW), .NODES(NODES), .MC_DEPTH(MCD), .TS_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .gig_mode_i(gig),
        .uc_enq_i(uc_enq), .uc_cls_i(uc_cls), .uc_handle_i(uc_h),
        .mc_enq_i(mc_enq), .mc_q_i(mc_q), .mc_handle_i(mc_h), .port_rdy_i(rdy),
        .deq_vld_o(deq_vld), .deq_handle_o(deq_h), .deq_cls_o(deq_cls),
        .deq_mc_o(deq_mc), .mc_ovf_o(mc_ovf)
    );

    function automatic int model_size();
        int s = 0;
        for (int c = 0; c < 8; c++) s += uq[c].size();
        for (int m = 0; m < 4; m++) s += mq[m].size();
        return s;
    endfunction

    // One clock: drive, predict, clock, compare.
    task automatic step(input bit ue, input int uc, input int uh, input bit me,
                        input int mqi, input int mh, input bit r, input string req);
        int nc = gig ? 8 : 4;
        int nm = gig ? 4 : 2;
        int ucnt = 0;
        bit e_vld = 0, e_mc = 0, e_ovf = 0, bad = 0;
        int e_h = 0, e_cls = 0;
        bit u_in, m_in, m_full;
        uc_enq = ue; uc_cls = 3'(uc); uc_h = HW'(uh);
        mc_enq = me; mc_q = 2'(mqi); mc_h = HW'(mh); rdy = r;
        for (int c = 0; c < 8; c++) ucnt += uq[c].size();
        u_in   = ue && uc < nc;
        m_in   = me && mqi < nm;
        m_full = m_in && mq[mqi].size() == MCD;
        e_ovf  = m_full;
        if (r) begin
            for (int c = nc - 1; c >= 0 && !e_vld; c--) begin
                bit u = uq[c].size() > 0;
                bit m = (c % 2 == 0) && (c / 2 < nm) && mq[c/2].size() > 0;
                if (u || m) begin
                    e_vld = 1; e_cls = c;
                    if (m && (!u || mq[c/2][0].t < uq[c][0].t)) begin
                        e_mc = 1; e_h = mq[c/2][0].h; void'(mq[c/2].pop_front());
                    end else begin
                        e_mc = 0; e_h = uq[c][0].h; void'(uq[c].pop_front());
                    end
                end
            end
        end
        if (u_in && ucnt < NODES) uq[uc].push_back('{uh, cyc});
        if (m_in && !m_full) mq[mqi].push_back('{mh, cyc});
        @(posedge clk);
        cyc++;
        #1;
        vectors++;
        if (deq_vld !== e_vld) begin
            bad = 1; $display("FAIL %s cyc %0d deq_vld got %b exp %b", req, cyc, deq_vld, e_vld);
        end else if (e_vld && (deq_h !== HW'(e_h) || deq_cls !== 3'(e_cls) || deq_mc !== e_mc)) begin
            bad = 1;
            $display("FAIL %s cyc %0d got h=%0d cls=%0d mc=%b exp h=%0d cls=%0d mc=%b",
                     req, cyc, deq_h, deq_cls, deq_mc, e_h, e_cls, e_mc);
        end
        if (mc_ovf !== e_ovf) begin
            bad = 1; $display("FAIL %s cyc %0d mc_ovf got %b exp %b", req, cyc, mc_ovf, e_ovf);
        end
        if (bad) misc++;
        uc_enq = 0; mc_enq = 0; rdy = 0;
    endtask

    task automatic idle(input bit r, input string req);
        step(0, 0, 0, 0, 0, 0, r, req);
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (model_size() > 0 && guard < 100) begin idle(1, req); guard++; end
        idle(1, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog expired");
        misc++;
        finish_run();
    end

    initial begin
        rdy = 1; uc_enq = 1; mc_enq = 1;
        repeat (4) @(posedge clk);
        #1;
        vectors++;
        if (deq_vld !== 1'b0 || mc_ovf !== 1'b0) begin
            misc++; $display("FAIL R1 in reset got vld=%b ovf=%b exp 0 0", deq_vld, mc_ovf);
        end
        uc_enq = 0; mc_enq = 0; rdy = 0;
        rst_n = 1;
        idle(1, "R1");
        idle(1, "R1");
        // R6 equal stamps: unicast first, then multicast
        step(1, 0, 11, 1, 0, 12, 0, "R6");
        idle(0, "R2");
        idle(1, "R6");
        idle(1, "R6");
        idle(1, "R6");
        // R6/R5 older multicast head wins in class 2
        step(0, 0, 0, 1, 1, 21, 0, "R5");
        step(1, 2, 22, 0, 0, 0, 0, "R6");
        idle(1, "R5");
        idle(1, "R6");
        // R7 strict priority
        step(1, 1, 31, 0, 0, 0, 0, "R7");
        step(1, 3, 32, 0, 0, 0, 0, "R7");
        idle(1, "R7");
        idle(1, "R7");
        // R8 out-of-layout enqueues dropped in narrow mode
        step(1, 5, 41, 1, 2, 42, 0, "R8");
        step(1, 7, 43, 1, 3, 44, 1, "R8");
        idle(1, "R8");
        // R3 and R4 order
        for (int i = 0; i < 3; i++) step(1, 1, 50 + i, 1, 1, 60 + i, 0, "R3");
        drain("R4");
        // R9 overflow, including a push to a full FIFO that is popped the same cycle
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 70 + i, 0, "R9");
        step(0, 0, 0, 1, 0, 79, 1, "R9");
        drain("R9");
        // R11 same-cycle enqueue not eligible
        step(1, 2, 81, 0, 0, 0, 1, "R11");
        idle(1, "R11");
        idle(1, "R11");
        // wide layout
        gig = 1;
        idle(0, "R8");
        step(1, 6, 91, 1, 3, 92, 0, "R5");
        step(1, 7, 93, 1, 2, 94, 0, "R5");
        drain("R7");
        // R10 pool exhaustion
        for (int i = 0; i < NODES + 2; i++) step(1, i % 8, 100 + i, 0, 0, 0, 0, "R10");
        drain("R10");
        // random runs in both layouts
        for (int pass = 0; pass < 2; pass++) begin
            gig = pass[0];
            idle(0, "R2");
            for (int i = 0; i < 4000; i++) begin
                step($urandom_range(0, 99) < 45, $urandom_range(0, 7), $urandom_range(0, 255),
                     $urandom_range(0, 99) < 35, $urandom_range(0, 3), $urandom_range(0, 255),
                     $urandom_range(0, 99) < 70, "R3");
            end
            drain("R4");
        end
        finish_run();
    end
endmodule